// File: doc/BRIEF.md
# Table-Driven Floppy Nibble Sequencer

This block is the bit-level engine of a floppy disk controller. A 4-bit sequencer state, the disk read pulse, the two host mode flags and the top bit of an 8-bit shift register are packed into an 8-bit index. That index selects one byte of a 256-entry sequencer table. Each byte holds a shift-register command and the next sequencer state. Because the table is a writable memory, the same hardware can run any read or write sequence that is loaded into it.

A host loads the table through a simple write port, then raises `run`. From then on the block takes one table step on every clock. While it runs, the host can pick a drive, switch between read and write mode, place a byte in the data latch, and read the shift register back. Step-motor phases, drive mechanics and nibble encoding belong to other blocks.

Top module: `dseq_top`

## Requirements
- R1: On each step the table index is {state[0], state[2], state[3], rd_pulse, write-mode flag, latch flag, shift[7], state[1]}, most significant bit first.
- R2: For a fetched byte b, the command is {b[4], b[5], b[6], b[7]} and b[3:0] becomes the next state on the same edge.
- R3: Command 0x0 sets the shift register to zero.
- R4: Command 0x9 shifts left and brings a 0 into bit 0. Command 0xD shifts left and brings a 1 into bit 0.
- R5: Command 0xA shifts right and places `wr_prot` in bit 7.
- R6: Command 0xB copies the data latch into the shift register. Every other command code leaves the shift register unchanged.
- R7: Host offset 0xF sets the write-mode flag and state bit 3. Offset 0xE clears both.
- R8: Host offset 0xD stores `host_wdata` in the data latch and sets the latch flag and state bit 2. Offset 0xC copies the shift register, as it was before the edge, to `host_rdata` and clears the latch flag and state bit 2.
- R9: Host offset 0xA drives `drive_sel` to 0 and offset 0xB drives it to 1. Offsets below 0xA change nothing.
- R10: While `run` is low, the state and the shift register hold. Synchronous reset clears the state, shift register, latch, flags, `drive_sel` and `host_rdata`.
- R11: When a host operation and a table step fall on the same edge, the host's change to state bit 2 or bit 3 wins over the table's next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Lets the sequencer take one step per clock |
| rd_pulse | input | 1 | Read pulse from the disk, used in the index for this cycle |
| wr_prot | input | 1 | Write-protect status |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write address |
| tbl_data | input | 8 | Table write data |
| host_en | input | 1 | Host access strobe |
| host_off | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Shift-register value captured by the last read |
| sr_out | output | 8 | Current shift-register value |
| seq_state | output | 4 | Current sequencer state |
| drive_sel | output | 1 | Selected drive |

## Verification
Directed tables first give every entry the same command, so that clear, both left shifts, the right shift with write protect, and the latch load each show a known byte after a known number of steps. A table that is a no-op everywhere except at one index tells whether the index is packed correctly, because the pulse input alone decides whether that entry is reached. A random table is then run with random pulse, write-protect, run and host traffic, and compared every cycle against a bench model. This exposes errors in nibble reversal, state feedback, and host-versus-table priority that the uniform tables cannot reveal.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int IDX_W = 8;
  localparam int ST_W  = 4;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_CLR  = 4'h0;
  localparam logic [CMD_W-1:0] CMD_SHL0 = 4'h9;
  localparam logic [CMD_W-1:0] CMD_SHRW = 4'hA;
  localparam logic [CMD_W-1:0] CMD_LOAD = 4'hB;
  localparam logic [CMD_W-1:0] CMD_SHL1 = 4'hD;

  localparam logic [3:0] OFF_DRV0  = 4'hA;
  localparam logic [3:0] OFF_DRV1  = 4'hB;
  localparam logic [3:0] OFF_RDSR  = 4'hC;
  localparam logic [3:0] OFF_WRLAT = 4'hD;
  localparam logic [3:0] OFF_RDMOD = 4'hE;
  localparam logic [3:0] OFF_WRMOD = 4'hF;

  // table bytes keep the command nibble mirrored
  function automatic logic [CMD_W-1:0] unmirror(input logic [CMD_W-1:0] n);
    for (int i = 0; i < CMD_W; i++) unmirror[i] = n[CMD_W-1-i];
  endfunction
endpackage

// File: rtl/dseq_table.sv
module dseq_table #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dseq_shifter.sv
module dseq_shifter
  import dseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CMD_W-1:0] cmd,
  input  logic [DW-1:0]    latch,
  input  logic             wp,
  output logic [DW-1:0]    sr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (run) begin
      case (cmd)
        CMD_CLR:  sr_q <= '0;
        CMD_SHL0: sr_q <= {sr_q[DW-2:0], 1'b0};
        CMD_SHL1: sr_q <= {sr_q[DW-2:0], 1'b1};
        CMD_SHRW: sr_q <= {wp, sr_q[DW-1:1]};
        CMD_LOAD: sr_q <= latch;
        default:  sr_q <= sr_q;
      endcase
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_CLR) |=> (sr_q == '0));
  p_shl_r4: assert property (@(posedge clk) disable iff (rst)
    (run && (cmd == CMD_SHL0 || cmd == CMD_SHL1)) |=>
      (sr_q == {$past(sr_q[DW-2:0]), $past(cmd[2])}));
  p_shr_r5: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_SHRW) |=> (sr_q == {$past(wp), $past(sr_q[DW-1:1])}));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_LOAD) |=> (sr_q == $past(latch)));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(sr_q));
endmodule

// File: rtl/dseq_host.sv
module dseq_host
  import dseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [3:0]    off,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sr,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] rdata_q,
  output logic          wmode_q,
  output logic          lflag_q,
  output logic          drive_q,
  output logic          st2_set,
  output logic          st2_clr,
  output logic          st3_set,
  output logic          st3_clr
);
  always_comb begin
    st2_set = en && off == OFF_WRLAT;
    st2_clr = en && off == OFF_RDSR;
    st3_set = en && off == OFF_WRMOD;
    st3_clr = en && off == OFF_RDMOD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      rdata_q <= '0;
      wmode_q <= 1'b0;
      lflag_q <= 1'b0;
      drive_q <= 1'b0;
    end else if (en) begin
      case (off)
        OFF_DRV0:  drive_q <= 1'b0;
        OFF_DRV1:  drive_q <= 1'b1;
        OFF_RDSR:  begin rdata_q <= sr; lflag_q <= 1'b0; end
        OFF_WRLAT: begin latch_q <= wdata; lflag_q <= 1'b1; end
        OFF_RDMOD: wmode_q <= 1'b0;
        OFF_WRMOD: wmode_q <= 1'b1;
        default:   ;
      endcase
    end
  end

  p_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (en && off == OFF_WRLAT) |=> (latch_q == $past(wdata) && lflag_q));
  p_read_r8: assert property (@(posedge clk) disable iff (rst)
    (en && off == OFF_RDSR) |=> (rdata_q == $past(sr) && !lflag_q));
  p_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (en && off == OFF_WRMOD) |=> wmode_q);
  p_drive_r9: assert property (@(posedge clk) disable iff (rst)
    (en && off == OFF_DRV1) |=> drive_q);
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          rd_pulse,
  input  logic          wr_prot,
  input  logic          tbl_we,
  input  logic [7:0]    tbl_addr,
  input  logic [7:0]    tbl_data,
  input  logic          host_en,
  input  logic [3:0]    host_off,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] sr_out,
  output logic [3:0]    seq_state,
  output logic          drive_sel
);
  logic [ST_W-1:0]  st_q, st_d;
  logic [IDX_W-1:0] idx;
  logic [7:0]       tbl_byte;
  logic [CMD_W-1:0] cmd;
  logic [DW-1:0]    sr_q, latch_q;
  logic             wmode_q, lflag_q;
  logic             st2_set, st2_clr, st3_set, st3_clr;

  // index layout is fixed: the table contents depend on it
  assign idx = {st_q[0], st_q[2], st_q[3], rd_pulse,
                wmode_q, lflag_q, sr_q[DW-1], st_q[1]};

  dseq_table #(.AW(IDX_W), .DW(8)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(idx), .rdata(tbl_byte)
  );

  assign cmd = unmirror(tbl_byte[7:4]);

  dseq_shifter #(.DW(DW)) u_sh (
    .clk(clk), .rst(rst), .run(run), .cmd(cmd), .latch(latch_q),
    .wp(wr_prot), .sr_q(sr_q)
  );

  dseq_host #(.DW(DW)) u_host (
    .clk(clk), .rst(rst), .en(host_en), .off(host_off), .wdata(host_wdata),
    .sr(sr_q), .latch_q(latch_q), .rdata_q(host_rdata), .wmode_q(wmode_q),
    .lflag_q(lflag_q), .drive_q(drive_sel), .st2_set(st2_set),
    .st2_clr(st2_clr), .st3_set(st3_set), .st3_clr(st3_clr)
  );

  always_comb begin
    st_d = run ? tbl_byte[ST_W-1:0] : st_q;
    if (st2_set) st_d[2] = 1'b1;
    if (st2_clr) st_d[2] = 1'b0;
    if (st3_set) st_d[3] = 1'b1;
    if (st3_clr) st_d[3] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign sr_out    = sr_q;
  assign seq_state = st_q;

  p_next_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !host_en) |=> (st_q == $past(tbl_byte[3:0])));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!run && !host_en) |=> $stable(st_q));
  p_host_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (host_en && host_off == OFF_WRMOD) |=> st_q[3]);
endmodule

// File: tb/sim_dseq_top.sv
module sim_dseq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0, rd_pulse = 1'b0, wr_prot = 1'b0;
  logic       tbl_we = 1'b0;
  logic [7:0] tbl_addr = '0, tbl_data = '0;
  logic       host_en = 1'b0;
  logic [3:0] host_off = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, sr_out;
  logic [3:0] seq_state;
  logic       drive_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_tbl [256];
  logic [7:0] m_sr, m_lat, m_rd;
  logic [3:0] m_st;
  logic       m_q7, m_q6, m_drv;
  string      sr_tag, st_tag;

  always #10 clk = ~clk;

  dseq_top u0 (
    .clk(clk), .rst(rst), .run(run), .rd_pulse(rd_pulse), .wr_prot(wr_prot),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .host_en(host_en), .host_off(host_off), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .sr_out(sr_out), .seq_state(seq_state),
    .drive_sel(drive_sel)
  );

  function automatic logic [7:0] enc(input logic [3:0] c, input logic [3:0] n);
    return {c[0], c[1], c[2], c[3], n};
  endfunction

  function automatic logic [7:0] f_idx(input logic [3:0] s, input logic p,
      input logic q7, input logic q6, input logic msb);
    return {s[0], s[2], s[3], p, q7, q6, msb, s[1]};
  endfunction

  function automatic logic [7:0] f_sr(input logic [3:0] c, input logic [7:0] s,
      input logic [7:0] l, input logic w);
    case (c)
      4'h0: return 8'h00;
      4'h9: return {s[6:0], 1'b0};
      4'hD: return {s[6:0], 1'b1};
      4'hA: return {w, s[7:1]};
      4'hB: return l;
      default: return s;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = 0; m_lat = 0; m_rd = 0; m_st = 0; m_q7 = 0; m_q6 = 0; m_drv = 0;
  endtask

  // one clock: update model at the edge, compare at the next falling edge
  task automatic tick();
    logic [7:0] b;
    logic [3:0] c;
    logic [7:0] n_sr, n_lat, n_rd;
    logic [3:0] n_st;
    logic       n_q7, n_q6, n_drv;
    @(posedge clk);
    b = m_tbl[f_idx(m_st, rd_pulse, m_q7, m_q6, m_sr[7])];
    c = {b[4], b[5], b[6], b[7]};
    n_sr = m_sr; n_st = m_st; n_lat = m_lat; n_rd = m_rd;
    n_q7 = m_q7; n_q6 = m_q6; n_drv = m_drv;
    sr_tag = "R6"; st_tag = "R1 R2";
    if (run) begin
      n_sr = f_sr(c, m_sr, m_lat, wr_prot);
      n_st = b[3:0];
      case (c)
        4'h0: sr_tag = "R3";
        4'h9, 4'hD: sr_tag = "R4";
        4'hA: sr_tag = "R5";
        default: sr_tag = "R6";
      endcase
    end else begin
      sr_tag = "R10"; st_tag = "R10";
    end
    if (host_en) begin
      st_tag = "R11";
      case (host_off)
        4'hA: n_drv = 0;
        4'hB: n_drv = 1;
        4'hC: begin n_rd = m_sr; n_q6 = 0; n_st[2] = 0; end
        4'hD: begin n_lat = host_wdata; n_q6 = 1; n_st[2] = 1; end
        4'hE: begin n_q7 = 0; n_st[3] = 0; end
        4'hF: begin n_q7 = 1; n_st[3] = 1; end
        default: ;
      endcase
    end
    if (tbl_we) m_tbl[tbl_addr] = tbl_data;
    m_sr = n_sr; m_st = n_st; m_lat = n_lat; m_rd = n_rd;
    m_q7 = n_q7; m_q6 = n_q6; m_drv = n_drv;
    @(negedge clk);
    check(sr_tag, sr_out, m_sr);
    check(st_tag, {4'h0, seq_state}, {4'h0, m_st});
    check("R8 rdata", host_rdata, m_rd);
    check("R9 drive", {7'h0, drive_sel}, {7'h0, m_drv});
  endtask

  task automatic fill(input logic [7:0] v);
    run = 0; host_en = 0;
    for (int i = 0; i < 256; i++) begin
      tbl_we = 1; tbl_addr = i[7:0]; tbl_data = v; tick();
    end
    tbl_we = 0;
  endtask

  task automatic host(input logic [3:0] o, input logic [7:0] d);
    host_en = 1; host_off = o; host_wdata = d; tick(); host_en = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10 reset values
    check("R10 reset sr", sr_out, 8'h00);
    check("R10 reset state", {4'h0, seq_state}, 8'h00);
    check("R10 reset rdata", host_rdata, 8'h00);

    // R4: shift in ones for eight steps
    fill(enc(4'hD, 4'h5));
    run = 1;
    repeat (8) tick();
    run = 0;
    check("R4 ones", sr_out, 8'hFF);
    check("R2 next state", {4'h0, seq_state}, 8'h05);

    // R3 clear
    fill(enc(4'h0, 4'h0));
    run = 1; tick(); run = 0;
    check("R3 clear", sr_out, 8'h00);

    // R5 right shift with write protect
    fill(enc(4'hA, 4'h0));
    wr_prot = 1; run = 1; repeat (3) tick(); run = 0; wr_prot = 0;
    check("R5 wp fill", sr_out, 8'hE0);

    // R10 run low holds
    wr_prot = 1; repeat (4) tick(); wr_prot = 0;
    check("R10 hold", sr_out, 8'hE0);

    // R6 / R8 latch load then read back
    fill(enc(4'hB, 4'h0));
    host(4'hD, 8'hA5);
    check("R8 latch flag", {4'h0, seq_state}, 8'h04);
    run = 1; tick(); run = 0;
    check("R6 load", sr_out, 8'hA5);
    host(4'hC, 8'h00);
    check("R8 read", host_rdata, 8'hA5);

    // R6 other code holds
    fill(enc(4'h3, 4'h0));
    run = 1; repeat (2) tick(); run = 0;
    check("R6 nop", sr_out, 8'hA5);

    // R9 drive select, low offset ignored
    host(4'hB, 8'h00);
    check("R9 drive1", {7'h0, drive_sel}, 8'h01);
    host(4'h3, 8'h00);
    check("R9 low offset", {7'h0, drive_sel}, 8'h01);
    host(4'hA, 8'h00);
    check("R9 drive0", {7'h0, drive_sel}, 8'h00);

    // R7 mode bits
    host(4'hF, 8'h00);
    check("R7 write mode", {4'h0, seq_state}, 8'h08);
    host(4'hE, 8'h00);
    check("R7 read mode", {4'h0, seq_state}, 8'h00);

    // R1 only index 0x10 (pulse high, all else zero) shifts a one in
    fill(enc(4'h0, 4'h0));
    run = 1; tick(); run = 0;
    fill(enc(4'h1, 4'h0));
    tbl_we = 1; tbl_addr = 8'h10; tbl_data = enc(4'hD, 4'h0); tick(); tbl_we = 0;
    run = 1; rd_pulse = 0; tick();
    check("R1 pulse low", sr_out, 8'h00);
    rd_pulse = 1; tick(); rd_pulse = 0; run = 0;
    check("R1 pulse high", sr_out, 8'h01);

    // R11 host and table on the same edge
    fill(enc(4'h1, 4'h0));
    run = 1; host_en = 1; host_off = 4'hF; tick(); host_en = 0; run = 0;
    check("R11 host wins", {4'h0, seq_state}, 8'h08);
    host(4'hE, 8'h00);

    // random table and traffic against the model
    run = 0;
    for (int i = 0; i < 256; i++) begin
      tbl_we = 1; tbl_addr = i[7:0]; tbl_data = $urandom; tick();
    end
    tbl_we = 0;
    for (int k = 0; k < 4000; k++) begin
      run        = ($urandom % 10) != 0;
      rd_pulse   = $urandom;
      wr_prot    = $urandom;
      host_en    = ($urandom % 5) == 0;
      host_off   = 4'h8 + 4'($urandom % 8);
      host_wdata = $urandom;
      tick();
    end
    run = 0; host_en = 0;

    // R10 synchronous reset mid-run
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    model_reset();
    check("R10 sync reset sr", sr_out, 8'h00);
    check("R10 sync reset state", {4'h0, seq_state}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule